// File: doc/BRIEF.md
# Peripheral Interrupt Flag Unit

This block sits inside a peripheral and turns that peripheral's internal event pulses into interrupt request lines. Each event sets a sticky flag bit. The flag stays set until software clears it. An enable mask decides which flags may raise a request.

Software reaches both vectors through a small register port with three addresses:
- a write-1-to-set address for the enable mask,
- a write-1-to-clear address for the enable mask,
- a status address that returns the flags on read and clears flags on a write of 1.

A flag raises its per-flag request while it is set and enabled. A build-time line map then routes the requests onto outgoing interrupt lines. Each line is the OR of the requests its mask selects, so one line can be dedicated to a single flag or shared by a group. With the default map, flags 0 to 3 each own a line and flags 4, 5 and 7 share line 4. Flag 6 is routed to no line.

Register writes take effect at the next rising clock edge. Reads, per-flag requests and interrupt lines are combinational from the stored state.

Top module: `irq_flag_unit`

## Requirements
- R1: While `rst_n` is low, all flags and all enable bits are 0, so `req_o` and `line_o` are all 0.
- R2: A 1 on `evt_i[i]` at a rising edge makes flag i 1 from that edge on. The flag stays 1 after the event is gone until software clears it.
- R3: A write to address 2 (the flag status address) clears at the next edge every flag whose `wdata` bit is 1. Flags written with 0 are unchanged.
- R4: If a flag's event and its clear arrive in the same cycle, the flag is 1 after the edge.
- R5: A write to address 0 (enable set) makes each enable bit whose `wdata` bit is 1 become 1. Bits written with 0 keep their value.
- R6: A write to address 1 (enable clear) makes each enable bit whose `wdata` bit is 1 become 0. Bits written with 0 keep their value.
- R7: `rdata` returns:
  - the enable mask when `addr` is 0 or 1,
  - the flag vector when `addr` is 2,
  - 0 when `addr` is 3.
- R8: `req_o[i]` is 1 exactly when flag i is 1 and enable bit i is 1.
- R9: `line_o[k]` is the OR of the `req_o` bits selected by mask k of `LINE_MAP`. In the default map, lines 0 to 3 follow `req_o[0]` to `req_o[3]`, line 4 is `req_o[4] | req_o[5] | req_o[7]`, and `req_o[6]` reaches no line.
- R10: A write to address 3 changes neither the flags nor the enable mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NFLAG | Event conditions, one per flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 enable set, 1 enable clear, 2 flags, 3 reserved) |
| wdata | input | NFLAG | Write data |
| rdata | output | NFLAG | Read data for `addr` |
| req_o | output | NFLAG | Per-flag request, flag AND enable |
| line_o | output | NLINE | Interrupt lines after grouping |

## Verification
The bench targets an event and a clear landing on the same flag in one cycle. A design where the clear wins would lose that interrupt.

It writes zero bits to both enable addresses. A design that treats these addresses as plain data registers would then wipe the mask.

It drives the flags that share line 4 one at a time, and it drives flag 6, which is mapped to no line. A wrong OR mask would either drop a group member or leak flag 6 onto a line.

It writes to the reserved address and reads it back. A loose address decode would alter the state on that write or return stale data on that read.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    typedef enum logic [1:0] {
        SEL_ENA_SET = 2'd0,
        SEL_ENA_CLR = 2'd1,
        SEL_FLAGS   = 2'd2,
        SEL_RSVD    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_flag_store.sv
module irq_flag_store #(
    parameter int NFLAG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] evt_i,
    input  logic [NFLAG-1:0] clr_i,
    output logic [NFLAG-1:0] flag_o
);
    logic [NFLAG-1:0] flag_d;

    // A new event beats a simultaneous clear.
    always_comb begin
        flag_d = (flag_o & ~clr_i) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_o <= '0;
        else        flag_o <= flag_d;
    end
endmodule

// File: rtl/irq_enable_mask.sv
module irq_enable_mask #(
    parameter int NFLAG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_i,
    input  logic [NFLAG-1:0] clr_i,
    output logic [NFLAG-1:0] en_o
);
    logic [NFLAG-1:0] en_d;

    always_comb begin
        en_d = (en_o | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_o <= '0;
        else        en_o <= en_d;
    end
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router #(
    parameter int                     NFLAG    = 8,
    parameter int                     NLINE    = 5,
    parameter logic [NLINE*NFLAG-1:0] LINE_MAP = '0
) (
    input  logic [NFLAG-1:0] req_i,
    output logic [NLINE-1:0] line_o
);
    for (genvar k = 0; k < NLINE; k++) begin : g_line
        localparam logic [NFLAG-1:0] SEL = LINE_MAP[k*NFLAG +: NFLAG];
        assign line_o[k] = |(req_i & SEL);
    end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
    import irq_flag_pkg::*;
#(
    parameter int                     NFLAG    = 8,
    parameter int                     NLINE    = 5,
    parameter logic [NLINE*NFLAG-1:0] LINE_MAP = {8'hB0, 8'h08, 8'h04, 8'h02, 8'h01}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] evt_i,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [NFLAG-1:0] wdata,
    output logic [NFLAG-1:0] rdata,
    output logic [NFLAG-1:0] req_o,
    output logic [NLINE-1:0] line_o
);
    reg_sel_e         sel;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] en_q;
    logic [NFLAG-1:0] en_set;
    logic [NFLAG-1:0] en_clr;
    logic [NFLAG-1:0] flag_clr;

    assign sel = reg_sel_e'(addr);

    always_comb begin
        en_set   = '0;
        en_clr   = '0;
        flag_clr = '0;
        if (wr_en) begin
            unique case (sel)
                SEL_ENA_SET: en_set   = wdata;
                SEL_ENA_CLR: en_clr   = wdata;
                SEL_FLAGS:   flag_clr = wdata;
                SEL_RSVD:    ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ENA_SET,
            SEL_ENA_CLR: rdata = en_q;
            SEL_FLAGS:   rdata = flag_q;
            SEL_RSVD:    rdata = '0;
        endcase
    end

    irq_flag_store #(.NFLAG(NFLAG)) flags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .clr_i  (flag_clr),
        .flag_o (flag_q)
    );

    irq_enable_mask #(.NFLAG(NFLAG)) mask_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (en_set),
        .clr_i (en_clr),
        .en_o  (en_q)
    );

    assign req_o = flag_q & en_q;

    irq_line_router #(.NFLAG(NFLAG), .NLINE(NLINE), .LINE_MAP(LINE_MAP)) route_i (
        .req_i  (req_o),
        .line_o (line_o)
    );
endmodule

// File: rtl/irq_flag_unit_chk.sv
module irq_flag_unit_chk #(
    parameter int NFLAG = 8,
    parameter int NLINE = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NFLAG-1:0] evt_i,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [NFLAG-1:0] wdata,
    input logic [NFLAG-1:0] flag_q,
    input logic [NFLAG-1:0] en_q,
    input logic [NFLAG-1:0] req_o,
    input logic [NLINE-1:0] line_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (flag_q == '0 && en_q == '0));

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i != '0 |=> (flag_q & $past(evt_i)) == $past(evt_i));

    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 2'd2) |=> (flag_q & $past(flag_q)) == $past(flag_q));

    assert_ena_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=> (en_q & $past(wdata)) == $past(wdata));

    assert_ena_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> (en_q & $past(wdata)) == '0);

    assert_ena_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == 2'd0 || addr == 2'd1)) |=> $stable(en_q));

    assert_line_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_o != '0 |-> req_o != '0);
endmodule

bind irq_flag_unit irq_flag_unit_chk #(.NFLAG(NFLAG), .NLINE(NLINE)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .flag_q (flag_q),
    .en_q   (en_q),
    .req_o  (req_o),
    .line_o (line_o)
);

// File: tb/irq_flag_unit_tb.sv
module irq_flag_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] req_o;
    logic [4:0] line_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_flag = '0;
    logic [7:0] m_en = '0;

    always #2.5 clk = ~clk;

    irq_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .req_o(req_o), .line_o(line_o)
    );

    function automatic logic [4:0] exp_lines(input logic [7:0] r);
        return {r[4] | r[5] | r[7], r[3], r[2], r[1], r[0]};
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0, 2'd1: return m_en;
            2'd2:       return m_flag;
            default:    return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One cycle: drive, check combinational outputs, advance model past the edge.
    task automatic step(input logic [7:0] e, input logic w, input logic [1:0] a,
                        input logic [7:0] d, input string tag);
        logic [7:0] nf;
        logic [7:0] ne;
        @(negedge clk);
        evt_i = e; wr_en = w; addr = a; wdata = d;
        #1;
        check({tag, " R7 rdata"}, rdata, exp_rdata(a));
        check({tag, " R8 req"}, req_o, m_flag & m_en);
        check({tag, " R9 lines"}, line_o, exp_lines(m_flag & m_en));
        nf = m_flag;
        ne = m_en;
        if (w && a == 2'd2) nf = nf & ~d;
        nf = nf | e;
        if (w && a == 2'd0) ne = ne | d;
        if (w && a == 2'd1) ne = ne & ~d;
        @(posedge clk);
        m_flag = nf;
        m_en = ne;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset req", req_o, 8'h00);
        check("R1 reset lines", line_o, 5'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: a single event pulse leaves a sticky flag.
        step(8'h01, 0, 2'd2, 8'h00, "R2 pulse");
        step(8'h00, 0, 2'd2, 8'h00, "R2 sticky");
        step(8'h00, 0, 2'd2, 8'h00, "R2 sticky2");

        // R5: enable-set with partial data; zero bits keep their value.
        step(8'h00, 1, 2'd0, 8'h0F, "R5 set");
        step(8'h00, 1, 2'd0, 8'h00, "R5 zero");
        step(8'h00, 0, 2'd1, 8'h00, "R5 readback");
        check("R5 mask kept", rdata, 8'h0F);

        // R6: enable-clear; zero bits have no effect.
        step(8'h00, 1, 2'd1, 8'h00, "R6 zero");
        step(8'h00, 1, 2'd1, 8'h01, "R6 clr");
        step(8'h00, 0, 2'd0, 8'h00, "R6 readback");
        check("R6 mask", rdata, 8'h0E);

        // R3: clear with mixed bits, then R4: set wins over clear.
        step(8'h06, 0, 2'd2, 8'h00, "R3 setup");
        step(8'h00, 1, 2'd2, 8'h02, "R3 clear");
        step(8'h00, 0, 2'd2, 8'h00, "R3 readback");
        check("R3 flags", rdata, 8'h05);
        step(8'h04, 1, 2'd2, 8'h04, "R4 collide");
        step(8'h00, 0, 2'd2, 8'h00, "R4 readback");
        check("R4 flag2 kept", rdata[2], 1'b1);

        // R9: shared line 4 members one at a time, flag 6 unrouted.
        step(8'h00, 1, 2'd0, 8'hFF, "R9 en all");
        step(8'h00, 1, 2'd2, 8'hFF, "R9 clr all");
        for (int i = 4; i < 8; i++) begin
            step(8'h01 << i, 0, 2'd2, 8'h00, "R9 raise");
            step(8'h00, 0, 2'd2, 8'h00, "R9 look");
            check("R9 shared line", line_o[4], (i == 6) ? 1'b0 : 1'b1);
            check("R9 low lines", line_o[3:0], 4'h0);
            step(8'h00, 1, 2'd2, 8'hFF, "R9 clr");
        end

        // R10: reserved address write has no effect, reads 0.
        step(8'hA5, 0, 2'd3, 8'h00, "R10 setup");
        step(8'h00, 1, 2'd3, 8'hFF, "R10 write");
        step(8'h00, 0, 2'd3, 8'h00, "R10 read");
        check("R10 rsvd reads zero", rdata, 8'h00);
        step(8'h00, 0, 2'd2, 8'h00, "R10 flags");
        check("R10 flags kept", rdata, 8'hA5);
        step(8'h00, 0, 2'd0, 8'h00, "R10 mask");
        check("R10 mask kept", rdata, 8'hFF);

        // Random traffic against the model.
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] e;
            e = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
            step(e, 1'($urandom), 2'($urandom), 8'($urandom), "rand");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule